// File: doc/BRIEF.md
# Multi-channel DMA interrupt status controller

This block holds the interrupt cause and enable state for eight DMA channels. Each channel owns a status register and an interrupt enable register. One-cycle event pulses from the transmit and receive DMA engines set cause bits in the status register. The block then builds four summary bits from those causes: transmit normal, receive normal, transmit abnormal and receive abnormal. Software clears a cause by writing a one to it.

Every channel drives its own receive interrupt line and its own transmit interrupt line, so each direction can be delivered as a separate message-signalled interrupt. The shared common interrupt line carries only the MAC-level request in that mode. A build parameter can instead fold all channel requests onto the common line. A read-only version register holds a fixed identifier in its low byte, which marks the multi-channel variant.

Software reaches the registers through a simple port that takes a channel index and a register offset. A read returns its data in the cycle after the request.

Top module: `dmairq_hub`

## Requirements
- R1: The eight channels are independent. An event or a register write on one channel does not change the status, enables or interrupt lines of any other channel.
- R2: Event bit b of channel c (`evt_pulse[c*15+b]`) sets status cause bit b at the next clock edge. The cause positions are: 0 tx complete, 1 tx stopped, 2 tx buffer unavailable, 3 tx jabber, 4 rx overflow, 5 tx underflow, 6 rx complete, 7 rx buffer unavailable, 8 rx stopped, 9 rx watchdog, 10 early tx, 12 rx fatal bus error, 13 tx fatal bus error, 14 early rx. Event bit 11 is ignored.
- R3: Writing status (offset 0) with a one in any of bits 19..0 clears that cause bit, and a zero leaves it unchanged. Summary bits cannot be written and follow their causes.
- R4: When an event and a write-one-to-clear hit the same cause bit in the same cycle, the bit ends up set.
- R5: The status summaries are built as follows. Bit 18 (tx normal) is the OR of enabled causes 0 and 2. Bit 17 (rx normal) is the OR of enabled causes 6 and 14. Bit 16 (tx abnormal) is the OR of enabled causes 1, 3, 5, 10 and 13. Bit 15 (rx abnormal) is the OR of enabled causes 4, 7, 8, 9 and 12. Each cause is enabled by the enable bit at its own position, except that enable bit 13 enables both fatal bus error causes (12 and 13).
- R6: An rx complete cause counts toward the rx normal summary and the rx interrupt only while enable bit 6 is set. Setting that bit later raises the summary and the interrupt at once.
- R7: `irq_tx[c]` is (bit 18 AND enable 18) OR (bit 16 AND enable 16). `irq_rx[c]` is (bit 17 AND enable 17) OR (bit 15 AND enable 15).
- R8: With per-channel delivery (default), `irq_common` follows `mac_irq` only, and channel requests do not reach it.
- R9: Offset 2 reads 0x00000010 from any channel index, and writes to it are ignored.
- R10: After reset, every status register reads 0 and every enable register reads 0x0007A061 (bits 18, 17, 16, 15, 13, 6, 5, 0). All interrupt lines and `reg_rvalid` are low.
- R11: A read request produces `reg_rvalid` high and the data on `reg_rdata` in the next cycle only. Offset 3 reads 0. Only enable bits 18..13 and 10..0 are writable, so writing all ones reads back 0x0007E7FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_ch | input | 3 | Channel index |
| reg_off | input | 2 | Register offset: 0 status, 1 enable, 2 version, 3 reserved |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| evt_pulse | input | 120 | Cause event pulses, 15 per channel, channel c at bits c*15+14..c*15 |
| mac_irq | input | 1 | MAC-level interrupt request |
| irq_common | output | 1 | Common interrupt line |
| irq_rx | output | 8 | Per-channel receive interrupt |
| irq_tx | output | 8 | Per-channel transmit interrupt |

## Verification
A wrong cause or enable flop shows up on the channel's interrupt line in the cycle after the offending edge, because the lines are combinational from the registers. A wrong summary term shows up the same way, or in the read data one cycle after a status read. A wrong channel decode shows up as activity on a neighbour's line or status, so the neighbour is read back after each event. A wrong priority between set and clear leaves a cleared bit that should have stayed set, and this is visible on the next read.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  localparam int CAUSE_W = 15;
  localparam int EN_W    = 19;
  localparam int DATA_W  = 32;

  // cause groups by summary
  localparam logic [CAUSE_W-1:0] M_CAUSE   = 15'h77FF;
  localparam logic [CAUSE_W-1:0] M_TX_NORM = 15'h0005;
  localparam logic [CAUSE_W-1:0] M_RX_NORM = 15'h4040;
  localparam logic [CAUSE_W-1:0] M_TX_ABN  = 15'h242A;
  localparam logic [CAUSE_W-1:0] M_RX_ABN  = 15'h1390;

  localparam int B_TX_NORM  = 18;
  localparam int B_RX_NORM  = 17;
  localparam int B_TX_ABN   = 16;
  localparam int B_RX_ABN   = 15;
  localparam int B_FATAL_EN = 13;
  localparam int B_FATAL_RX = 12;
  localparam int B_FATAL_TX = 13;

  localparam logic [EN_W-1:0] EN_WMASK = 19'h7E7FF;
  localparam logic [EN_W-1:0] EN_RESET = 19'h7A061;

  typedef enum logic [1:0] {
    OFF_STAT = 2'd0,
    OFF_IEN  = 2'd1,
    OFF_VER  = 2'd2,
    OFF_RSVD = 2'd3
  } reg_off_e;

  typedef struct packed {
    logic tx_norm;
    logic rx_norm;
    logic tx_abn;
    logic rx_abn;
  } summ_t;

endpackage

// File: rtl/dmairq_rst_sync.sv
module dmairq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/dmairq_chan.sv
module dmairq_chan
  import dmairq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] evt,
  input  logic               st_wr,
  input  logic               en_wr,
  input  logic [EN_W-1:0]    wdata,
  output logic [DATA_W-1:0]  stat_rd,
  output logic [DATA_W-1:0]  en_rd,
  output logic               irq_rx,
  output logic               irq_tx
);
  logic [CAUSE_W-1:0] st_q, st_d, st_set, st_clr, gate, eff;
  logic [EN_W-1:0]    en_q, en_d;
  logic               st_ce, en_ce;
  summ_t              summ;

  // next state: set wins over clear
  always_comb begin
    st_set = evt & M_CAUSE;
    st_clr = st_wr ? wdata[CAUSE_W-1:0] : '0;
    st_d   = (st_q & ~st_clr) | st_set;
    st_ce  = st_wr | (|st_set);
    en_d   = wdata & EN_WMASK;
    en_ce  = en_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= EN_RESET;
    end else begin
      if (st_ce) st_q <= st_d;
      if (en_ce) en_q <= en_d;
    end
  end

  // one enable bit covers both fatal causes
  always_comb begin
    gate             = en_q[CAUSE_W-1:0];
    gate[B_FATAL_RX] = en_q[B_FATAL_EN];
    gate[B_FATAL_TX] = en_q[B_FATAL_EN];
    eff              = st_q & gate;
    summ.tx_norm     = |(eff & M_TX_NORM);
    summ.rx_norm     = |(eff & M_RX_NORM);
    summ.tx_abn      = |(eff & M_TX_ABN);
    summ.rx_abn      = |(eff & M_RX_ABN);
  end

  assign irq_tx  = (summ.tx_norm & en_q[B_TX_NORM]) | (summ.tx_abn & en_q[B_TX_ABN]);
  assign irq_rx  = (summ.rx_norm & en_q[B_RX_NORM]) | (summ.rx_abn & en_q[B_RX_ABN]);
  assign stat_rd = {13'b0, summ.tx_norm, summ.rx_norm, summ.tx_abn, summ.rx_abn, st_q};
  assign en_rd   = {13'b0, en_q};
endmodule

// File: rtl/dmairq_regif.sv
module dmairq_regif
  import dmairq_pkg::*;
#(
  parameter int         NCH    = 8,
  parameter logic [7:0] VER_ID = 8'h10,
  localparam int        CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [CH_W-1:0]            reg_ch,
  input  logic [1:0]                 reg_off,
  input  logic [NCH-1:0][DATA_W-1:0] stat_all,
  input  logic [NCH-1:0][DATA_W-1:0] en_all,
  output logic [NCH-1:0]             st_wr,
  output logic [NCH-1:0]             en_wr,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rvalid
);
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, rd_ce;
  reg_off_e          off;

  assign off = reg_off_e'(reg_off);

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      st_wr[c] = reg_wr && (int'(reg_ch) == c) && (off == OFF_STAT);
      en_wr[c] = reg_wr && (int'(reg_ch) == c) && (off == OFF_IEN);
    end
  end

  always_comb begin
    rdata_d = '0;
    unique case (off)
      OFF_STAT: if (int'(reg_ch) < NCH) rdata_d = stat_all[reg_ch];
      OFF_IEN:  if (int'(reg_ch) < NCH) rdata_d = en_all[reg_ch];
      OFF_VER:  rdata_d = {24'b0, VER_ID};
      default:  rdata_d = '0;
    endcase
    rd_ce = reg_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (rd_ce) rdata_q <= rdata_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/dmairq_hub.sv
module dmairq_hub
  import dmairq_pkg::*;
#(
  parameter int         NCH       = 8,
  parameter bit         PERCH_IRQ = 1'b1,
  parameter logic [7:0] VER_ID    = 8'h10,
  localparam int        CH_W      = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int        EVT_W     = NCH * CAUSE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CH_W-1:0]   reg_ch,
  input  logic [1:0]        reg_off,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic              mac_irq,
  output logic              irq_common,
  output logic [NCH-1:0]    irq_rx,
  output logic [NCH-1:0]    irq_tx
);
  logic                       rst_q;
  logic [NCH-1:0][DATA_W-1:0] stat_all, en_all;
  logic [NCH-1:0]             st_wr, en_wr, ch_rx, ch_tx;
  logic                       unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:EN_W];

  dmairq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  dmairq_regif #(.NCH(NCH), .VER_ID(VER_ID)) u_regif (
    .clk(clk), .rst_n(rst_q), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_ch(reg_ch), .reg_off(reg_off), .stat_all(stat_all), .en_all(en_all),
    .st_wr(st_wr), .en_wr(en_wr), .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmairq_chan u_chan (
      .clk(clk), .rst_n(rst_q),
      .evt(evt_pulse[g*CAUSE_W +: CAUSE_W]),
      .st_wr(st_wr[g]), .en_wr(en_wr[g]),
      .wdata(reg_wdata[EN_W-1:0]),
      .stat_rd(stat_all[g]), .en_rd(en_all[g]),
      .irq_rx(ch_rx[g]), .irq_tx(ch_tx[g])
    );
  end

  if (PERCH_IRQ) begin : g_split
    assign irq_rx     = ch_rx;
    assign irq_tx     = ch_tx;
    assign irq_common = mac_irq;
  end else begin : g_merged
    assign irq_rx     = '0;
    assign irq_tx     = '0;
    assign irq_common = mac_irq | (|ch_rx) | (|ch_tx);
  end
endmodule

// File: rtl/dmairq_hub_chk.sv
module dmairq_hub_chk #(
  parameter int NCH       = 8,
  parameter int EVT_W     = 120,
  parameter bit PERCH_IRQ = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [1:0]       reg_off,
  input logic [31:0]      reg_rdata,
  input logic             reg_rvalid,
  input logic [EVT_W-1:0] evt_pulse,
  input logic             mac_irq,
  input logic             irq_common,
  input logic [NCH-1:0]   irq_rx,
  input logic [NCH-1:0]   irq_tx
);
  assert_rvalid_after_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  assert_no_spurious_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  assert_version_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_off == 2'd2) |=> (reg_rdata == 32'h0000_0010));

  assert_rx_rise_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|irq_rx) |-> $past((|evt_pulse) || reg_wr));

  assert_tx_rise_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|irq_tx) |-> $past((|evt_pulse) || reg_wr));

  assert_irq_drop_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(|irq_rx) || $fell(|irq_tx)) |-> $past(reg_wr));

  assert_common_carries_mac_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mac_irq |-> irq_common);

  if (PERCH_IRQ) begin : g_split_chk
    assert_common_mac_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mac_irq |-> !irq_common);
  end
endmodule

bind dmairq_hub dmairq_hub_chk #(.NCH(NCH), .EVT_W(EVT_W), .PERCH_IRQ(PERCH_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_q), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_off(reg_off),
  .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .evt_pulse(evt_pulse),
  .mac_irq(mac_irq), .irq_common(irq_common), .irq_rx(irq_rx), .irq_tx(irq_tx)
);

// File: tb/dmairq_hub_tb.sv
module dmairq_hub_tb;
  localparam int NCH = 8;
  localparam int CW  = 15;

  logic              clk, rst_n, reg_wr, reg_rd, mac_irq;
  logic [2:0]        reg_ch;
  logic [1:0]        reg_off;
  logic [31:0]       reg_wdata, reg_rdata;
  logic              reg_rvalid, irq_common;
  logic [NCH*CW-1:0] evt_pulse;
  logic [NCH-1:0]    irq_rx, irq_tx;
  int                n_run, n_fail;
  logic [31:0]       rv;

  dmairq_hub u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_ch(reg_ch), .reg_off(reg_off), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .evt_pulse(evt_pulse),
    .mac_irq(mac_irq), .irq_common(irq_common), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [2:0]  ch;
    logic [14:0] evt;
    logic [31:0] st;
    logic        rx;
    logic        tx;
  } vec_t;

  // event on one channel, expected status and lines with reset enables
  localparam vec_t VEC [8] = '{
    '{3'd0, 15'h0001, 32'h0004_0001, 1'b0, 1'b1},
    '{3'd3, 15'h0040, 32'h0002_0040, 1'b1, 1'b0},
    '{3'd5, 15'h0020, 32'h0001_0020, 1'b0, 1'b1},
    '{3'd7, 15'h1000, 32'h0000_9000, 1'b1, 1'b0},
    '{3'd1, 15'h0004, 32'h0000_0004, 1'b0, 1'b0},
    '{3'd2, 15'h0800, 32'h0000_0000, 1'b0, 1'b0},
    '{3'd6, 15'h0041, 32'h0006_0041, 1'b1, 1'b1},
    '{3'd4, 15'h2000, 32'h0001_2000, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [1:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_ch = ch[2:0]; reg_off = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [1:0] off, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_ch = ch[2:0]; reg_off = off;
    @(negedge clk);
    reg_rd = 1'b0;
    if (reg_rvalid !== 1'b1) check("R11 rvalid", {31'b0, reg_rvalid}, 32'h1);
    d = reg_rdata;
  endtask

  task automatic pulse(input int ch, input logic [14:0] e);
    @(negedge clk);
    evt_pulse = '0;
    evt_pulse[ch*CW +: CW] = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_ch = '0; reg_off = '0;
    reg_wdata = '0; evt_pulse = '0; mac_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check("R10 irq_rx", {24'b0, irq_rx}, 32'h0);
    check("R10 irq_tx", {24'b0, irq_tx}, 32'h0);
    check("R10 irq_common", {31'b0, irq_common}, 32'h0);
    check("R10 rvalid", {31'b0, reg_rvalid}, 32'h0);
    for (int c = 0; c < NCH; c++) begin
      rd(c, 2'd1, rv); check("R10 enable", rv, 32'h0007_A061);
      rd(c, 2'd0, rv); check("R10 status", rv, 32'h0);
    end

    // table walk: R1 R2 R5 R7 R8 R3
    for (int i = 0; i < 8; i++) begin
      pulse(VEC[i].ch, VEC[i].evt);
      check("R7 irq_rx", {31'b0, irq_rx[VEC[i].ch]}, {31'b0, VEC[i].rx});
      check("R7 irq_tx", {31'b0, irq_tx[VEC[i].ch]}, {31'b0, VEC[i].tx});
      check("R8 common idle", {31'b0, irq_common}, 32'h0);
      rd(VEC[i].ch, 2'd0, rv); check("R2 R5 status", rv, VEC[i].st);
      rd((VEC[i].ch + 1) % NCH, 2'd0, rv); check("R1 neighbour status", rv, 32'h0);
      check("R1 other lines", {16'b0, irq_rx, irq_tx},
            {16'b0, 8'(VEC[i].rx) << VEC[i].ch, 8'(VEC[i].tx) << VEC[i].ch});
      wr(VEC[i].ch, 2'd0, 32'h000F_FFFF);
      check("R3 lines after clear", {16'b0, irq_rx, irq_tx}, 32'h0);
      rd(VEC[i].ch, 2'd0, rv); check("R3 status after clear", rv, 32'h0);
    end

    // R6 rx complete gated by its enable
    wr(3, 2'd1, 32'h0007_A021);
    pulse(3, 15'h0040);
    check("R6 irq_rx gated", {31'b0, irq_rx[3]}, 32'h0);
    rd(3, 2'd0, rv); check("R6 no summary", rv, 32'h0000_0040);
    wr(3, 2'd1, 32'h0007_A061);
    check("R6 irq_rx on enable", {31'b0, irq_rx[3]}, 32'h1);
    rd(3, 2'd0, rv); check("R6 summary on enable", rv, 32'h0002_0040);
    wr(3, 2'd0, 32'h000F_FFFF);

    // R4 set beats same-cycle clear
    @(negedge clk);
    evt_pulse = '0; evt_pulse[0] = 1'b1;
    reg_wr = 1'b1; reg_ch = 3'd0; reg_off = 2'd0; reg_wdata = 32'h0000_0001;
    @(negedge clk);
    evt_pulse = '0; reg_wr = 1'b0;
    rd(0, 2'd0, rv); check("R4 set wins", rv, 32'h0004_0001);

    // R3 zeros and summary-only writes leave causes
    wr(0, 2'd0, 32'h0);
    rd(0, 2'd0, rv); check("R3 zero write", rv, 32'h0004_0001);
    wr(0, 2'd0, 32'h0004_0000);
    rd(0, 2'd0, rv); check("R3 summary write", rv, 32'h0004_0001);

    // R7 summary enable gates the line, not the summary
    wr(0, 2'd1, 32'h0003_A061);
    check("R7 tx line masked", {31'b0, irq_tx[0]}, 32'h0);
    rd(0, 2'd0, rv); check("R5 summary still set", rv, 32'h0004_0001);
    wr(0, 2'd1, 32'h0007_A061);
    check("R7 tx line restored", {31'b0, irq_tx[0]}, 32'h1);
    wr(0, 2'd0, 32'h0000_0001);
    check("R3 tx line cleared", {31'b0, irq_tx[0]}, 32'h0);
    rd(0, 2'd0, rv); check("R3 cleared", rv, 32'h0);

    // R11 enable write mask, reserved offset, rvalid pulse
    wr(2, 2'd1, 32'hFFFF_FFFF);
    rd(2, 2'd1, rv); check("R11 enable mask", rv, 32'h0007_E7FF);
    rd(1, 2'd1, rv); check("R1 enable neighbour", rv, 32'h0007_A061);
    wr(2, 2'd1, 32'h0007_A061);
    rd(5, 2'd3, rv); check("R11 reserved", rv, 32'h0);
    @(negedge clk);
    check("R11 rvalid single", {31'b0, reg_rvalid}, 32'h0);

    // R9 version
    rd(4, 2'd2, rv); check("R9 version", rv, 32'h0000_0010);
    wr(0, 2'd2, 32'hFFFF_FFFF);
    rd(0, 2'd2, rv); check("R9 version after write", rv, 32'h0000_0010);

    // R8 common line carries mac request
    @(negedge clk);
    mac_irq = 1'b1;
    #1 check("R8 common high", {31'b0, irq_common}, 32'h1);
    mac_irq = 1'b0;
    #1 check("R8 common low", {31'b0, irq_common}, 32'h0);

    summary();
    $finish;
  end
endmodule